// File: doc/BRIEF.md
# Inter-processor doorbell message unit

This block lets cores signal one another with doorbell messages. A send command carries a 32-bit message word. The word holds a message type, a broadcast flag and a processor-ID tag. The unit decodes the type into one of two doorbell classes, normal or critical. It then sets the matching pending bit in every core that the word targets. A core is targeted when the broadcast flag is set, or when its processor-ID register equals the tag.

A clear command names one core, the issuing core, and carries a message word of the same layout. It removes the decoded pending bit in that core only. Guest message types and codes with no meaning are accepted on both commands and change nothing.

Each core has a hard-interrupt request. A send that targets the core raises the request. The request falls once the core has no doorbell of either class left pending. Delivering the interrupt is left to the consumer of these outputs.

Top module: `ipi_doorbell_unit`

## Requirements
- R1: After reset, every pending bit and every hard-interrupt request is 0. Core c holds processor ID PIR_BASE + c*PIR_STRIDE, and this value never changes.
- R2: The type field is bits [31:27] of the message word. Code 0 selects the normal doorbell (db_pend_o) and code 1 selects the critical doorbell (crit_pend_o).
- R3: Codes 2, 3 and 4 are the guest doorbell, guest critical and guest machine-check types. These codes, and every code from 5 to 31, leave all outputs unchanged for both send and clear.
- R4: A send with the broadcast flag (bit 26) set sets the decoded pending bit in every core, whatever the tag holds.
- R5: A send with bit 26 clear sets the decoded bit only in cores whose processor ID equals the tag in bits [13:0]. A tag that matches no core has no effect.
- R6: Every core whose pending bit is set by a send has hard_irq_o raised on the following cycle.
- R7: A clear removes only the decoded class bit in core clr_core_i. The other class bit in that core, and all bits in other cores, are untouched. Bits 26 and [13:0] of a clear word are ignored.
- R8: When a send and a clear hit the same bit of the same core in the same cycle, the bit ends up set.
- R9: hard_irq_o of a core falls when that core has no pending bit of either class. It stays high while either bit remains.
- R10: All outputs are registered. A command presented in one cycle is visible after the next rising clock edge. Pending bits hold their value when no command is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_valid_i | input | 1 | Send command strobe |
| send_msg_i | input | 32 | Send message word |
| clr_valid_i | input | 1 | Clear command strobe |
| clr_core_i | input | CORE_W | Index of the core issuing the clear |
| clr_msg_i | input | 32 | Clear message word |
| db_pend_o | output | N_CORES | Normal doorbell pending, one bit per core |
| crit_pend_o | output | N_CORES | Critical doorbell pending, one bit per core |
| hard_irq_o | output | N_CORES | Hard-interrupt request, one bit per core |

## Verification
The assertions check several rules on every cycle. A decoded send must leave its bit set on the next cycle, even when a clear hits the same bit. A clear with no competing send must drop its bit. A raised interrupt request must always have a pending bit behind it. A send of a guest type must leave the pending vectors unchanged, and the processor-ID registers must never move. Some behaviour only the bench scenarios can show: that a given tag selects exactly the right cores, that a tag matching no core does nothing, that broadcast reaches every core, and that a clear leaves the other class bit and the other cores alone.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;
  localparam int MSG_W     = 32;
  localparam int KIND_HI   = 31;
  localparam int KIND_LO   = 27;
  localparam int BCAST_BIT = 26;
  localparam int TAG_W     = 14;

  typedef enum logic [KIND_HI-KIND_LO:0] {
    KIND_DB     = 5'd0,
    KIND_CRIT   = 5'd1,
    KIND_G_DB   = 5'd2,
    KIND_G_CRIT = 5'd3,
    KIND_G_MC   = 5'd4
  } msg_kind_e;

  typedef struct packed {
    logic             hit_db;
    logic             hit_crit;
    logic             bcast;
    logic [TAG_W-1:0] tag;
  } dbell_cmd_t;
endpackage

// File: rtl/dbell_msg_decode.sv
module dbell_msg_decode
  import ipi_doorbell_pkg::*;
(
  input  logic             valid_i,
  input  logic [MSG_W-1:0] msg_i,
  output dbell_cmd_t       cmd_o
);
  logic [KIND_HI-KIND_LO:0] kind;
  logic                     unused_mid;

  assign kind       = msg_i[KIND_HI:KIND_LO];
  assign unused_mid = ^msg_i[BCAST_BIT-1:TAG_W];

  always_comb begin
    cmd_o          = '0;
    cmd_o.bcast    = msg_i[BCAST_BIT];
    cmd_o.tag      = msg_i[TAG_W-1:0];
    // guest and unknown kinds fall through with no hit
    unique case (kind)
      KIND_DB:   cmd_o.hit_db   = valid_i;
      KIND_CRIT: cmd_o.hit_crit = valid_i;
      default:   ;
    endcase
  end
endmodule

// File: rtl/dbell_core_slot.sv
module dbell_core_slot
  import ipi_doorbell_pkg::*;
#(
  parameter logic [TAG_W-1:0] PIR_RESET = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  dbell_cmd_t send_i,
  input  logic       clr_db_i,
  input  logic       clr_crit_i,
  output logic       db_o,
  output logic       crit_o,
  output logic       irq_o
);
  logic [TAG_W-1:0] pir_q;
  logic             target;
  logic             set_db, set_crit;
  logic             db_d, crit_d, irq_d;
  logic             db_q, crit_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pir_q <= PIR_RESET;
    else         pir_q <= pir_q;
  end

  assign target   = send_i.bcast || (send_i.tag == pir_q);
  assign set_db   = send_i.hit_db && target;
  assign set_crit = send_i.hit_crit && target;

  // send has priority over a same-cycle clear
  assign db_d   = set_db   | (db_q   & ~clr_db_i);
  assign crit_d = set_crit | (crit_q & ~clr_crit_i);
  assign irq_d  = (set_db | set_crit) ? 1'b1 : ((db_d | crit_d) ? irq_q : 1'b0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q   <= 1'b0;
      crit_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      db_q   <= db_d;
      crit_q <= crit_d;
      irq_q  <= irq_d;
    end
  end

  assign db_o   = db_q;
  assign crit_o = crit_q;
  assign irq_o  = irq_q;

  // R1
  pir_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pir_q == PIR_RESET);
  // R6
  irq_on_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_db || set_crit) |=> irq_q);
  // R8
  send_wins_db_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_db |=> db_q);
  // R8
  send_wins_crit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_crit |=> crit_q);
  // R7
  clr_db_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_db_i && !set_db) |=> !db_q);
  // R7
  clr_crit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_crit_i && !set_crit) |=> !crit_q);
  // R9
  irq_backed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (db_q || crit_q));
endmodule

// File: rtl/ipi_doorbell_unit.sv
module ipi_doorbell_unit
  import ipi_doorbell_pkg::*;
#(
  parameter int               N_CORES    = 4,
  parameter logic [TAG_W-1:0] PIR_BASE   = 14'd8,
  parameter logic [TAG_W-1:0] PIR_STRIDE = 14'd3,
  localparam int              CORE_W     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               send_valid_i,
  input  logic [MSG_W-1:0]   send_msg_i,
  input  logic               clr_valid_i,
  input  logic [CORE_W-1:0]  clr_core_i,
  input  logic [MSG_W-1:0]   clr_msg_i,
  output logic [N_CORES-1:0] db_pend_o,
  output logic [N_CORES-1:0] crit_pend_o,
  output logic [N_CORES-1:0] hard_irq_o
);
  dbell_cmd_t send_cmd, clr_cmd;
  logic       unused_clr_fields;

  dbell_msg_decode u_send_dec (
    .valid_i (send_valid_i),
    .msg_i   (send_msg_i),
    .cmd_o   (send_cmd)
  );

  dbell_msg_decode u_clr_dec (
    .valid_i (clr_valid_i),
    .msg_i   (clr_msg_i),
    .cmd_o   (clr_cmd)
  );

  assign unused_clr_fields = clr_cmd.bcast ^ (^clr_cmd.tag);

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    localparam logic [TAG_W-1:0] PIR_C = PIR_BASE + TAG_W'(c) * PIR_STRIDE;
    logic sel;
    assign sel = (clr_core_i == CORE_W'(c));

    dbell_core_slot #(.PIR_RESET(PIR_C)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .send_i     (send_cmd),
      .clr_db_i   (clr_cmd.hit_db && sel),
      .clr_crit_i (clr_cmd.hit_crit && sel),
      .db_o       (db_pend_o[c]),
      .crit_o     (crit_pend_o[c]),
      .irq_o      (hard_irq_o[c])
    );
  end

  logic send_guest;
  assign send_guest = send_valid_i && (send_msg_i[KIND_HI:KIND_LO] > 5'd1);

  // R3
  guest_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_guest && !clr_valid_i) |=> ($stable(db_pend_o) && $stable(crit_pend_o)));
  // R2
  db_send_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_i && send_msg_i[KIND_HI:KIND_LO] == 5'd0 && send_msg_i[BCAST_BIT])
      |=> (&db_pend_o));
endmodule

// File: tb/ipi_doorbell_unit_tb_top.sv
`timescale 1ns/1ps
module ipi_doorbell_unit_tb_top;
  localparam int N = 4;
  localparam int CW = 2;
  localparam logic [13:0] PBASE = 14'd8;
  localparam logic [13:0] PSTEP = 14'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send_v = 1'b0, clr_v = 1'b0;
  logic [31:0] send_m = '0, clr_m = '0;
  logic [CW-1:0] clr_c = '0;
  logic [N-1:0] db, crit, irq;

  always #2 clk = ~clk;

  ipi_doorbell_unit #(.N_CORES(N), .PIR_BASE(PBASE), .PIR_STRIDE(PSTEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .send_valid_i(send_v), .send_msg_i(send_m),
    .clr_valid_i(clr_v), .clr_core_i(clr_c), .clr_msg_i(clr_m),
    .db_pend_o(db), .crit_pend_o(crit), .hard_irq_o(irq)
  );

  typedef struct packed { logic [N-1:0] db; logic [N-1:0] cr; logic [N-1:0] ir; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [N-1:0] m_db = '0, m_cr = '0, m_ir = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [31:0] mk(input int kind, input bit bc, input int tag);
    return {5'(kind), bc, 12'd0, 14'(tag)};
  endfunction

  task automatic chk(input string r, input logic [N-1:0] act, input logic [N-1:0] ex, input string what);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", r, what, act, ex);
    end
  endtask

  // driver: applies one cycle of command and pushes the expected state
  task automatic op(input string r, input bit sv, input logic [31:0] sm,
                    input bit cv, input int cc, input logic [31:0] cm);
    logic [N-1:0] sdb, scr, cdb, ccr;
    @(negedge clk);
    send_v = sv; send_m = sm; clr_v = cv; clr_c = CW'(cc); clr_m = cm;
    sdb = '0; scr = '0; cdb = '0; ccr = '0;
    for (int c = 0; c < N; c++) begin
      bit tgt;
      tgt = sm[26] || (sm[13:0] == PBASE + 14'(c) * PSTEP);
      if (sv && tgt && sm[31:27] == 5'd0) sdb[c] = 1'b1;
      if (sv && tgt && sm[31:27] == 5'd1) scr[c] = 1'b1;
    end
    if (cv && cm[31:27] == 5'd0) cdb[cc] = 1'b1;
    if (cv && cm[31:27] == 5'd1) ccr[cc] = 1'b1;
    m_db = sdb | (m_db & ~cdb);
    m_cr = scr | (m_cr & ~ccr);
    for (int c = 0; c < N; c++)
      if (sdb[c] || scr[c]) m_ir[c] = 1'b1;
      else if (!m_db[c] && !m_cr[c]) m_ir[c] = 1'b0;
    exp_q.push_back('{db: m_db, cr: m_cr, ir: m_ir});
    tag_q.push_back(r);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string r;
      e = exp_q.pop_front();
      r = tag_q.pop_front();
      chk(r, db, e.db, "db_pend");
      chk(r, crit, e.cr, "crit_pend");
      chk(r, irq, e.ir, "hard_irq");
    end
  end

  task automatic idle(input string r);
    op(r, 0, '0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", db, '0, "reset db");
    chk("R1", crit, '0, "reset crit");
    chk("R1", irq, '0, "reset irq");
    // R5 unicast normal doorbell to core 1 (pir 11), R2 code 0
    op("R5", 1, mk(0, 0, 11), 0, 0, '0);
    // R2 code 1 to core 3 (pir 17), R6 irq
    op("R2", 1, mk(1, 0, 17), 0, 0, '0);
    // R5 tag matching nobody
    op("R5", 1, mk(0, 0, 5), 0, 0, '0);
    // R10 hold with no command
    idle("R10");
    // R4 broadcast critical, tag irrelevant
    op("R4", 1, mk(1, 1, 5), 0, 0, '0);
    // R3 guest and unknown kinds: broadcast sends and clears do nothing
    op("R3", 1, mk(2, 1, 0), 0, 0, '0);
    op("R3", 1, mk(3, 1, 0), 1, 3, mk(4, 0, 0));
    op("R3", 1, mk(4, 1, 0), 1, 1, mk(3, 0, 0));
    op("R3", 1, mk(9, 1, 11), 1, 1, mk(31, 0, 0));
    // R7 clear db in core 1; crit stays, irq stays (R9)
    op("R7", 0, '0, 1, 1, mk(0, 1, 17));
    // R9 clear crit in core 1 -> nothing left, irq drops
    op("R9", 0, '0, 1, 1, mk(1, 0, 0));
    // R8 same-cycle send and clear of core 0 db
    op("R8", 1, mk(0, 0, 8), 1, 0, mk(0, 0, 0));
    // R7 clear crit core 2 while unicast db to core 3
    op("R7", 1, mk(0, 0, 17), 1, 2, mk(1, 0, 0));
    // R4 broadcast normal doorbell
    op("R4", 1, mk(0, 1, 0), 0, 0, '0);
    // drain everything, R9 irq falls per core
    for (int c = 0; c < N; c++) begin
      op("R7", 0, '0, 1, c, mk(0, 0, 0));
      op("R9", 0, '0, 1, c, mk(1, 0, 0));
    end
    // R6 re-raise after drain
    op("R6", 1, mk(1, 0, 14), 0, 0, '0);
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule